// File: doc/BRIEF.md
# Tile Row Convert Unit

This block holds a small two-dimensional store of 32-bit words (16 rows of 64 bytes by default). On request it reads one row of that store and returns a 512-bit vector of 16 dword lanes, converting every lane on the way. The request names the row and a 64-byte chunk of that row through one packed 32-bit selector. It also names a conversion mode and the number of bytes per row that count as configured.

Five conversions are offered:
- signed 32-bit integer to single precision;
- single precision to bfloat16, placed in the upper or the lower half of each dword;
- single precision to half precision, placed in the upper or the lower half of each dword.

Every conversion rounds to nearest with ties to even and raises no exception indication. A lane whose source word lies past the configured row width comes out as zero. The store is filled one dword at a time through a plain write port.

The result is registered. It appears one cycle after the request with a single-cycle valid pulse and stays on the output until the next request.

Top module: `tile_row_cvt`

## Requirements
- R1: After reset, `valid` is 0 and `vout` is all zero.
- R2: A request taken with `start` high at a rising edge gives `valid` high for exactly the following cycle, with the result on `vout`. With `start` low, `valid` is 0 and `vout` keeps its last value.
- R3: The row index is `sel[15:0]`. A row index at or above the row count (16) gives an all-zero vector.
- R4: The chunk index is `sel[31:16]`. Lane i reads source dword chunk*16 + i of the row. With 64-byte rows, any nonzero chunk therefore gives an all-zero vector.
- R5: A lane whose source dword index is at or beyond floor(`colsb`/4) is zero in all 32 bits. For example, colsb 24 or 26 keeps lanes 0 to 5, and colsb 0 clears every lane.
- R6: Mode 0 converts a signed int32 to fp32 with round-to-nearest-even. Zero gives +0.0, and 0x80000000 gives exactly -2^31 (0xCF000000).
- R7: Modes 1 and 2 convert fp32 to bf16 with round-to-nearest-even. Overflow gives signed infinity. Any NaN gives the quiet NaN 0x7FC0 with its sign kept, and infinities keep their sign.
- R8: Modes 3 and 4 convert fp32 to fp16 with round-to-nearest-even:
  - a result beyond the largest finite value (0x7BFF) becomes signed infinity;
  - small values become fp16 subnormals or signed zero, rounded to even at the subnormal step;
  - NaN gives 0x7E00 with its sign kept.
- R9: In modes 1 and 3 the 16-bit result sits in bits [31:16] of each dword with bits [15:0] zero. In modes 2 and 4 it sits in bits [15:0] with bits [31:16] zero.
- R10: Mode codes 5, 6 and 7 give an all-zero vector.
- R11: With `wr_en` high at a rising edge, `wr_data` is stored at row `wr_row`, dword `wr_col`. A later request reads the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Store write strobe |
| wr_row | input | 4 | Store write row |
| wr_col | input | 4 | Store write dword within the row |
| wr_data | input | 32 | Store write data |
| start | input | 1 | Request strobe |
| sel | input | 32 | Chunk index in [31:16], row index in [15:0] |
| mode | input | 3 | Conversion mode, 0 to 4 (5 to 7 give zero) |
| colsb | input | 7 | Configured bytes per row, 0 to 64 |
| valid | output | 1 | One-cycle result strobe |
| vout | output | 512 | Converted vector, lane i in bits [32i+31:32i] |

## Verification
The checker watches the handshake on every cycle. After each request it confirms the valid pulse, and it confirms that the output is held while no request arrives. It also checks every request that must clear the vector: a reserved mode, a row out of range or a configured width under one dword. For all half-placement modes it confirms that the unused half of every lane is clear.

The converted values themselves can only be shown by the bench's scenarios. These are the rounding ties, the overflow to infinity, the subnormal step of half precision, the NaN encodings and the partial-width cutoffs. They are checked against fixed bit patterns worked out from the requirements.

// File: rtl/tr_pkg.sv
package tr_pkg;
   typedef enum logic [2:0] {
      TR_I2F   = 3'd0,
      TR_BF_HI = 3'd1,
      TR_BF_LO = 3'd2,
      TR_HF_HI = 3'd3,
      TR_HF_LO = 3'd4
   } tr_mode_e;

   localparam logic [15:0] TR_BF_QNAN = 16'h7FC0;
   localparam logic [14:0] TR_HF_QNAN = 15'h7E00;
   localparam logic [14:0] TR_HF_INF  = 15'h7C00;
endpackage

// File: rtl/tr_store.sv
module tr_store #(
   parameter int ROWS   = 16,
   parameter int ROW_DW = 16,
   localparam int RW    = $clog2(ROWS),
   localparam int CW    = $clog2(ROW_DW)
) (
   input  logic                  clk,
   input  logic                  wr_en,
   input  logic [RW-1:0]         wr_row,
   input  logic [CW-1:0]         wr_col,
   input  logic [31:0]           wr_data,
   input  logic [RW-1:0]         rd_idx,
   output logic [ROW_DW*32-1:0]  row_o
);
   logic [31:0] mem [ROWS][ROW_DW];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_row][wr_col] <= wr_data;
   end

   for (genvar j = 0; j < ROW_DW; j++) begin : g_rd
      assign row_o[j*32 +: 32] = mem[rd_idx][j];
   end
endmodule

// File: rtl/tr_i2f.sv
module tr_i2f (
   input  logic [31:0] a,
   output logic [31:0] y
);
   logic        s, rnd;
   logic [31:0] mag, nrm;
   logic [4:0]  lz;
   logic [30:0] body;

   always_comb begin
      s   = a[31];
      mag = s ? (~a + 32'd1) : a;
      lz  = 5'd0;
      for (int k = 0; k < 32; k++) begin
         if (mag[k]) lz = 5'(31 - k);
      end
      nrm  = mag << lz;
      rnd  = nrm[7] & ((|nrm[6:0]) | nrm[8]);
      body = {8'(8'd158 - {3'd0, lz}), nrm[30:8]} + {30'd0, rnd};
      y    = nrm[31] ? {s, body} : 32'd0;
   end
endmodule

// File: rtl/tr_f2h.sv
module tr_f2h (
   input  logic [31:0] a,
   output logic [15:0] y
);
   import tr_pkg::*;
   logic        s, rn, rs;
   logic [7:0]  e, sh;
   logic [22:0] m;
   logic [47:0] ext;
   logic [14:0] nb;

   always_comb begin
      s   = a[31];
      e   = a[30:23];
      m   = a[22:0];
      sh  = 8'd126 - e;
      ext = {1'b1, m, 24'd0} >> sh;
      rn  = m[12] & ((|m[11:0]) | m[13]);
      rs  = ext[23] & ((|ext[22:0]) | (|ext[47:34]) | ext[24]);
      nb  = {5'(e - 8'd112), m[22:13]} + {14'd0, rn};
      if (e == 8'hFF)       y = (m != 23'd0) ? {s, TR_HF_QNAN} : {s, TR_HF_INF};
      else if (e >= 8'd143) y = {s, TR_HF_INF};
      else if (e >= 8'd113) y = {s, nb};
      else if (e >= 8'd102) y = {s, 5'd0, ext[33:24]} + {15'd0, rs};
      else                  y = {s, 15'd0};
   end
endmodule

// File: rtl/tr_lane.sv
module tr_lane (
   input  logic [2:0]  mode,
   input  logic [31:0] a,
   output logic [31:0] y
);
   import tr_pkg::*;
   logic [31:0] f32;
   logic [15:0] hf, bf;
   logic        bcarry, bnan;

   tr_i2f u_i2f (.a(a), .y(f32));
   tr_f2h u_f2h (.a(a), .y(hf));

   always_comb begin
      bnan   = (a[30:23] == 8'hFF) && (a[22:0] != 23'd0);
      bcarry = (a[15:0] > 16'h8000) || ((a[15:0] == 16'h8000) && a[16]);
      bf     = bnan ? {a[31], TR_BF_QNAN[14:0]} : (a[31:16] + {15'd0, bcarry});
      case (tr_mode_e'(mode))
         TR_I2F:   y = f32;
         TR_BF_HI: y = {bf, 16'd0};
         TR_BF_LO: y = {16'd0, bf};
         TR_HF_HI: y = {hf, 16'd0};
         TR_HF_LO: y = {16'd0, hf};
         default:  y = 32'd0;
      endcase
   end
endmodule

// File: rtl/tile_row_cvt.sv
module tile_row_cvt #(
   parameter int ROWS      = 16,
   parameter int ROW_BYTES = 64,
   parameter int VEC_BITS  = 512,
   localparam int LANES    = VEC_BITS / 32,
   localparam int ROW_DW   = ROW_BYTES / 4,
   localparam int RW       = $clog2(ROWS),
   localparam int CW       = $clog2(ROW_DW),
   localparam int CBW      = $clog2(ROW_BYTES + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [RW-1:0]       wr_row,
   input  logic [CW-1:0]       wr_col,
   input  logic [31:0]         wr_data,
   input  logic                start,
   input  logic [31:0]         sel,
   input  logic [2:0]          mode,
   input  logic [CBW-1:0]      colsb,
   output logic                valid,
   output logic [VEC_BITS-1:0] vout
);
   if (VEC_BITS % 32 != 0) begin : g_bad_vec
      $error("VEC_BITS must be a multiple of 32");
   end
   if (ROW_BYTES % 4 != 0 || (1 << CW) != ROW_DW) begin : g_bad_row
      $error("ROW_BYTES must be four times a power of two");
   end
   if ((1 << RW) != ROWS || ROWS * ROW_BYTES > 1024) begin : g_bad_rows
      $error("ROWS must be a power of two and the store at most 1024 bytes");
   end

   logic [ROW_DW*32-1:0] row_data;
   logic [15:0]          row_idx, chunk;
   logic                 row_ok;
   logic [31:0]          base, limit;
   logic [VEC_BITS-1:0]  lanes;
   logic                 valid_q;
   logic [VEC_BITS-1:0]  vout_q;

   assign row_idx = sel[15:0];
   assign chunk   = sel[31:16];
   assign row_ok  = 32'(row_idx) < 32'(ROWS);
   assign base    = 32'(chunk) * 32'(LANES);
   assign limit   = 32'(colsb >> 2);

   tr_store #(.ROWS(ROWS), .ROW_DW(ROW_DW)) u_store (
      .clk(clk), .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col),
      .wr_data(wr_data), .rd_idx(row_idx[RW-1:0]), .row_o(row_data)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [31:0] src, word, cvt;
      logic        in_rng;
      assign src    = base + 32'(i);
      assign in_rng = row_ok && (src < limit) && (src < 32'(ROW_DW));
      assign word   = row_data[src[CW-1:0]*32 +: 32];
      tr_lane u_lane (.mode(mode), .a(word), .y(cvt));
      assign lanes[i*32 +: 32] = in_rng ? cvt : 32'd0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         vout_q  <= '0;
      end else begin
         valid_q <= start;
         if (start) vout_q <= lanes;
      end
   end

   assign valid = valid_q;
   assign vout  = vout_q;
endmodule

// File: rtl/tr_checks.sv
module tr_checks #(
   parameter int ROWS     = 16,
   parameter int VEC_BITS = 512,
   parameter int CBW      = 7,
   localparam int LANES   = VEC_BITS / 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start,
   input logic [31:0]         sel,
   input logic [2:0]          mode,
   input logic [CBW-1:0]      colsb,
   input logic                valid,
   input logic [VEC_BITS-1:0] vout
);
   logic [LANES-1:0] lo_nz, hi_nz;
   for (genvar i = 0; i < LANES; i++) begin : g_half
      assign lo_nz[i] = |vout[i*32 +: 16];
      assign hi_nz[i] = |vout[i*32+16 +: 16];
   end

   a_r2_valid_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> valid);
   a_r2_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> !valid);
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> $stable(vout));
   a_r3_row_range: assert property (@(posedge clk) disable iff (!rst_n)
      (start && 32'(sel[15:0]) >= 32'(ROWS)) |=> vout == '0);
   a_r5_no_width: assert property (@(posedge clk) disable iff (!rst_n)
      (start && colsb < CBW'(4)) |=> vout == '0);
   a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (start && mode > 3'd4) |=> vout == '0);
   a_r9_hi_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (start && (mode == 3'd1 || mode == 3'd3)) |=> lo_nz == '0);
   a_r9_lo_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (start && (mode == 3'd2 || mode == 3'd4)) |=> hi_nz == '0);
endmodule

bind tile_row_cvt tr_checks #(.ROWS(ROWS), .VEC_BITS(VEC_BITS), .CBW(CBW)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .sel(sel), .mode(mode),
   .colsb(colsb), .valid(valid), .vout(vout)
);

// File: tb/sim_tile_row_cvt.sv
module sim_tile_row_cvt;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [3:0]   wr_row = '0;
   logic [3:0]   wr_col = '0;
   logic [31:0]  wr_data = '0;
   logic         start = 1'b0;
   logic [31:0]  sel = '0;
   logic [2:0]   mode = '0;
   logic [6:0]   colsb = '0;
   logic         valid;
   logic [511:0] vout;
   logic [511:0] res;
   int n_run = 0;
   int n_fail = 0;

   logic [31:0] i_in [16], i_ex [16], b_in [16], h_in [16];
   logic [15:0] b_ex [16], h_ex [16];

   always #4 clk = ~clk;

   tile_row_cvt u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row),
      .wr_col(wr_col), .wr_data(wr_data), .start(start), .sel(sel), .mode(mode),
      .colsb(colsb), .valid(valid), .vout(vout));

   task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input int r, input int c, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_row = 4'(r); wr_col = 4'(c); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic issue(input logic [31:0] s, input logic [2:0] m, input logic [6:0] cb);
      @(negedge clk);
      start = 1'b1; sel = s; mode = m; colsb = cb;
      @(negedge clk);
      start = 1'b0;
      chk("R2 valid after request", 512'(valid), 512'(1));
      res = vout;
      @(negedge clk);
      chk("R2 valid single cycle", 512'(valid), 512'(0));
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 reset valid", 512'(valid), 512'(0));
      chk("R1 reset vout", vout, 512'(0));
      rst_n = 1'b1;
   endtask

   task automatic t_load();
      for (int c = 0; c < 16; c++) begin
         wr(3, c, i_in[c]);
         wr(5, c, b_in[c]);
         wr(7, c, h_in[c]);
         wr(0, c, 32'h0000_0009);
      end
   endtask

   task automatic t_i2f();
      issue(32'd3, 3'd0, 7'd64);
      for (int i = 0; i < 16; i++) chk($sformatf("R6 i2f lane %0d", i), 512'(res[i*32 +: 32]), 512'(i_ex[i]));
   endtask

   task automatic t_bf();
      issue(32'd5, 3'd1, 7'd64);
      for (int i = 0; i < 16; i++) chk($sformatf("R7 R9 bf16 high lane %0d", i), 512'(res[i*32 +: 32]), 512'({b_ex[i], 16'h0}));
      issue(32'd5, 3'd2, 7'd64);
      for (int i = 0; i < 16; i++) chk($sformatf("R7 R9 bf16 low lane %0d", i), 512'(res[i*32 +: 32]), 512'({16'h0, b_ex[i]}));
   endtask

   task automatic t_hf();
      issue(32'd7, 3'd3, 7'd64);
      for (int i = 0; i < 16; i++) chk($sformatf("R8 R9 fp16 high lane %0d", i), 512'(res[i*32 +: 32]), 512'({h_ex[i], 16'h0}));
      issue(32'd7, 3'd4, 7'd64);
      for (int i = 0; i < 16; i++) chk($sformatf("R8 R9 fp16 low lane %0d", i), 512'(res[i*32 +: 32]), 512'({16'h0, h_ex[i]}));
   endtask

   task automatic t_width();
      logic [6:0] cbs [2] = '{7'd24, 7'd26};
      foreach (cbs[k]) begin
         issue(32'd3, 3'd0, cbs[k]);
         for (int i = 0; i < 16; i++)
            chk($sformatf("R5 colsb %0d lane %0d", cbs[k], i), 512'(res[i*32 +: 32]), 512'(i < 6 ? i_ex[i] : 32'd0));
      end
      issue(32'd3, 3'd0, 7'd0);
      chk("R5 colsb 0", res, 512'(0));
   endtask

   task automatic t_chunk();
      issue(32'h0001_0003, 3'd0, 7'd64);
      chk("R4 chunk 1", res, 512'(0));
      issue(32'h0002_0007, 3'd3, 7'd64);
      chk("R4 chunk 2", res, 512'(0));
   endtask

   task automatic t_row();
      issue(32'd0, 3'd0, 7'd64);
      for (int i = 0; i < 16; i++) chk($sformatf("R3 row 0 lane %0d", i), 512'(res[i*32 +: 32]), 512'(32'h4110_0000));
      issue(32'h0000_0013, 3'd0, 7'd64);
      chk("R3 row 19 out of range", res, 512'(0));
      issue(32'h0000_0010, 3'd3, 7'd64);
      chk("R3 row 16 out of range", res, 512'(0));
   endtask

   task automatic t_reserved();
      for (int m = 5; m < 8; m++) begin
         issue(32'd3, 3'(m), 7'd64);
         chk($sformatf("R10 mode %0d", m), res, 512'(0));
      end
   endtask

   task automatic t_write();
      wr(3, 2, 32'd1000);
      issue(32'd3, 3'd0, 7'd64);
      chk("R11 rewritten lane 2", 512'(res[64 +: 32]), 512'(32'h447A_0000));
      chk("R11 neighbour lane 1", 512'(res[32 +: 32]), 512'(i_ex[1]));
   endtask

   task automatic t_hold();
      logic [511:0] snap;
      issue(32'd5, 3'd1, 7'd64);
      snap = vout;
      @(negedge clk);
      sel = 32'd7; mode = 3'd4;
      repeat (3) @(negedge clk);
      chk("R2 output held without request", vout, snap);
      chk("R2 valid low without request", 512'(valid), 512'(0));
   endtask

   initial begin
      i_in = '{32'd0, 32'd1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0100_0001,
               32'h0100_0003, 32'd100, 32'hFFFF_FF9C, 32'd2, 32'd3, 32'h00FF_FFFF,
               32'h0100_0002, 32'hFEFF_FFFF, 32'd7, 32'd1000};
      i_ex = '{32'h0000_0000, 32'h3F80_0000, 32'hBF80_0000, 32'hCF00_0000, 32'h4F00_0000, 32'h4B80_0000,
               32'h4B80_0002, 32'h42C8_0000, 32'hC2C8_0000, 32'h4000_0000, 32'h4040_0000, 32'h4B7F_FFFF,
               32'h4B80_0001, 32'hCB80_0000, 32'h40E0_0000, 32'h447A_0000};
      b_in = '{32'h3F80_0000, 32'h3F80_8000, 32'h3F81_8000, 32'h3F80_8001, 32'h7FC0_0001, 32'hFFC1_2345,
               32'hFF80_0000, 32'h7F7F_FFFF, 32'h0000_0000, 32'h8000_0000, 32'h3F80_FFFF, 32'h4049_0FDB,
               32'hC049_0FDB, 32'h7F80_0000, 32'h7F80_0001, 32'h0001_8000};
      b_ex = '{16'h3F80, 16'h3F80, 16'h3F82, 16'h3F81, 16'h7FC0, 16'hFFC0, 16'hFF80, 16'h7F80,
               16'h0000, 16'h8000, 16'h3F81, 16'h4049, 16'hC049, 16'h7F80, 16'h7FC0, 16'h0002};
      h_in = '{32'h3F80_0000, 32'h477F_E000, 32'h477F_F000, 32'hC780_0000, 32'h3380_0000, 32'h3300_0000,
               32'h3340_0000, 32'h3880_0000, 32'h7F80_0001, 32'hFFC0_0000, 32'hFF80_0000, 32'h8000_0000,
               32'h3F80_1000, 32'h3F80_3000, 32'hB3C0_0000, 32'h387F_C000};
      h_ex = '{16'h3C00, 16'h7BFF, 16'h7C00, 16'hFC00, 16'h0001, 16'h0000, 16'h0001, 16'h0400,
               16'h7E00, 16'hFE00, 16'hFC00, 16'h8000, 16'h3C00, 16'h3C02, 16'h8002, 16'h03FF};
      repeat (2) @(negedge clk);
      t_reset();
      t_load();
      t_i2f();
      t_bf();
      t_hf();
      t_width();
      t_chunk();
      t_row();
      t_reserved();
      t_write();
      t_hold();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule